// File: doc/BRIEF.md
# Reference Clock Selector with Primary/Secondary Designation

This block chooses which of two reference clocks feeds the downstream dividers. Input A is the crystal/reference path and input B is the external clock path. A designation bit marks one input as primary, and the other input becomes the secondary, which serves as the backup. The output clock moves between the two inputs without glitches. The outgoing clock is gated off on its own falling edge. The incoming clock is gated on only after the outgoing gate has been seen low in the new clock's domain and two rising edges of the new clock have passed.

The switchover mode field has two operating styles. In manual style, an external select pin picks primary (low) or secondary (high). A flag from the multi-purpose I/O logic can take the pin away from clock selection, and selection then follows the designation bit alone. In automatic style, each input has a missing-clock detector driven by a free-running check clock. When the primary shows no edge for a programmable number of check-clock cycles, the block falls back to the secondary. It returns to the primary once the primary's edges come back. A dead input that is not wanted has its gate cleared asynchronously, so a stalled clock cannot block a switchover. A status output gives the physical input that drives the output. A sticky flag records any loss of the primary.

Top module: `refclk_selector`

## Requirements
- R1: With designation bit 0, manual mode (mode = 00) and select pin low, the output follows input A and the status reads 0.
- R2: With designation bit 1 and select pin low, the output follows input B. With the pin held at one level, flipping only the designation bit swaps the active input.
- R3: In manual mode the select pin high picks the secondary, which is the input that is not designated primary.
- R4: While the manual-frequency-control-2 flag is high in manual mode, the select pin has no effect and the output follows the designated primary.
- R5: In automatic mode (mode upper bit = 1), the select pin has no effect and the output follows the primary while the primary is running.
- R6: In automatic mode, a primary that shows no edge for `miss_limit` check-clock cycles is declared missing and the output moves to the secondary. When the primary's edges resume, the output returns to the primary.
- R7: The loss flag sets whenever the primary is missing. It stays set until a `clr_loss` pulse arrives while the primary is present. A clear pulse while the primary is still missing has no effect.
- R8: The output never carries a high or low pulse shorter than the shorter half-period of the two inputs, and the two input gates are never open together.
- R9: `active_is_b` reads 1 when input B drives the output and 0 when input A drives it.
- R10: During reset the output is low, `active_is_b` is 0 and `loss_flag` is 0.
- R11: The lower bit of the mode field has no effect. Mode 01 behaves as manual mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_clk | input | 1 | Free-running check clock for control and detection |
| clk_a | input | 1 | Reference input A (crystal/reference path) |
| clk_b | input | 1 | Reference input B (external clock path) |
| prim_is_b | input | 1 | Designation bit: 0 makes A primary, 1 makes B primary |
| sw_mode | input | 2 | Switchover mode; bit 1 = 1 selects automatic |
| mfc2_active | input | 1 | Takes the select pin away from clock selection |
| sel_pin | input | 1 | Manual select: 0 primary, 1 secondary |
| clr_loss | input | 1 | One-cycle pulse that clears the loss flag |
| miss_limit | input | CNT_W | Check-clock cycles without an edge before an input counts as missing |
| clk_out | output | 1 | Selected glitch-free clock |
| active_is_b | output | 1 | Physical input currently driving the output |
| loss_flag | output | 1 | Sticky record of a loss of the primary |

## Verification
A control change passes through the pin synchronizer (two check cycles) and the decision register (one cycle). The old gate then closes on its next falling edge. The new gate opens after two of its own rising edges and a falling edge. Status follows two check cycles after that, so a switch settles in well under 100 ns. The bench therefore waits 100 ns after each change before it checks status. It measures frequency by counting output rising edges over a 280 ns window, allowing one edge of tolerance. A stopped clock is detected after `miss_limit` plus about four check cycles, and the bench allows 300 ns before it checks. A running monitor records the narrowest output pulse, and the bench compares that value with the shorter input half-period at the end of the run.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} src_e;
  localparam int NUM_SRC  = 2;
  localparam int AUTO_BIT = 1;
endpackage

// File: rtl/refsel_edge_mon.sv
module refsel_edge_mon #(
  parameter int CNT_W = 8
) (
  input  logic             chk_clk,
  input  logic             rst_n,
  input  logic             mon_clk,
  input  logic [CNT_W-1:0] limit,
  output logic             missing
);
  logic             tog_q;
  logic [2:0]       sync_q;
  logic             chg;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             miss_q, miss_d;

  // toggle flop in the monitored domain
  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= ~tog_q;
  end

  always_ff @(posedge chk_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], tog_q};
  end

  assign chg = sync_q[2] ^ sync_q[1];

  always_comb begin
    cnt_d  = cnt_q;
    miss_d = miss_q;
    if (chg) begin
      cnt_d  = '0;
      miss_d = 1'b0;
    end else if (cnt_q >= limit) begin
      miss_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge chk_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      miss_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      miss_q <= miss_d;
    end
  end

  assign missing = miss_q;

  // an observed edge always withdraws the missing verdict
  assert_edge_clears_miss_R6: assert property (@(posedge chk_clk) disable iff (!rst_n)
    chg |=> !miss_q);
endmodule

// File: rtl/refsel_gate_leg.sv
module refsel_gate_leg (
  input  logic clk_in,
  input  logic clr_n,
  input  logic want,
  input  logic other_gate,
  output logic gate
);
  logic req;
  logic s1_q, s2_q, gate_q;

  assign req = want & ~other_gate;

  always_ff @(posedge clk_in or negedge clr_n) begin
    if (!clr_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= req;
      s2_q <= s1_q;
    end
  end

  // gate updates while the clock is low, so the AND stays clean
  always_ff @(negedge clk_in or negedge clr_n) begin
    if (!clr_n) gate_q <= 1'b0;
    else        gate_q <= s2_q;
  end

  assign gate = gate_q;
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
  import refsel_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prim_is_b,
  input  logic [1:0]         sw_mode,
  input  logic               mfc2_active,
  input  logic               sel_pin,
  input  logic               clr_loss,
  input  logic [NUM_SRC-1:0] miss,
  input  logic [NUM_SRC-1:0] gate_raw,
  output logic [NUM_SRC-1:0] want,
  output logic [NUM_SRC-1:0] kill,
  output logic               active_is_b,
  output logic               loss_flag
);
  logic               pin_s1_q, pin_s2_q;
  logic [NUM_SRC-1:0] gs1_q, gs2_q;
  src_e               sel_q, sel_d, target;
  logic               loss_q, loss_d;
  logic               stat_q, stat_d;
  logic [NUM_SRC-1:0] kill_q, kill_d;
  logic               auto_m, prim_miss, cur_miss, done, use_sec;
  logic               unused_mode_lo;

  assign unused_mode_lo = sw_mode[0];

  always_comb begin
    auto_m    = sw_mode[AUTO_BIT];
    prim_miss = prim_is_b ? miss[1] : miss[0];
    cur_miss  = (sel_q == SRC_B) ? miss[1] : miss[0];
    done      = (sel_q == SRC_B) ? (gs2_q == 2'b10) : (gs2_q == 2'b01);
    use_sec   = auto_m ? prim_miss : (pin_s2_q & ~mfc2_active);
    target    = src_e'(prim_is_b ^ use_sec);
    sel_d     = (done || cur_miss) ? target : sel_q;
    loss_d    = prim_miss ? 1'b1 : (clr_loss ? 1'b0 : loss_q);
    stat_d    = stat_q;
    if (gs2_q == 2'b01)      stat_d = 1'b0;
    else if (gs2_q == 2'b10) stat_d = 1'b1;
    kill_d[0] = miss[0] & (sel_q == SRC_B);
    kill_d[1] = miss[1] & (sel_q == SRC_A);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s1_q <= 1'b0;
      pin_s2_q <= 1'b0;
      gs1_q    <= '0;
      gs2_q    <= '0;
      sel_q    <= SRC_A;
      loss_q   <= 1'b0;
      stat_q   <= 1'b0;
      kill_q   <= '0;
    end else begin
      pin_s1_q <= sel_pin;
      pin_s2_q <= pin_s1_q;
      gs1_q    <= gate_raw;
      gs2_q    <= gs1_q;
      sel_q    <= sel_d;
      loss_q   <= loss_d;
      stat_q   <= stat_d;
      kill_q   <= kill_d;
    end
  end

  assign want        = {sel_q == SRC_B, sel_q == SRC_A};
  assign kill        = kill_q;
  assign active_is_b = stat_q;
  assign loss_flag   = loss_q;

  assert_loss_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (loss_q && !clr_loss) |=> loss_q);

  assert_loss_needs_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loss_q) |-> $past(prim_miss));

  assert_mfc2_primary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_mode[AUTO_BIT] && mfc2_active && done) |=> (sel_q == src_e'($past(prim_is_b))));
endmodule

// File: rtl/refclk_selector.sv
module refclk_selector
  import refsel_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             rst_n,
  input  logic             chk_clk,
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             prim_is_b,
  input  logic [1:0]       sw_mode,
  input  logic             mfc2_active,
  input  logic             sel_pin,
  input  logic             clr_loss,
  input  logic [CNT_W-1:0] miss_limit,
  output logic             clk_out,
  output logic             active_is_b,
  output logic             loss_flag
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [NUM_SRC-1:0] src_clk, miss, gate, want, kill, clr_n;

  always_ff @(posedge chk_clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign src_clk = {clk_b, clk_a};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    refsel_edge_mon #(.CNT_W(CNT_W)) i_mon (
      .chk_clk (chk_clk),
      .rst_n   (rst_int_n),
      .mon_clk (src_clk[i]),
      .limit   (miss_limit),
      .missing (miss[i])
    );
    assign clr_n[i] = rst_int_n & ~kill[i];
    refsel_gate_leg i_leg (
      .clk_in     (src_clk[i]),
      .clr_n      (clr_n[i]),
      .want       (want[i]),
      .other_gate (gate[NUM_SRC-1-i]),
      .gate       (gate[i])
    );
  end

  refsel_ctrl i_ctrl (
    .clk         (chk_clk),
    .rst_n       (rst_int_n),
    .prim_is_b   (prim_is_b),
    .sw_mode     (sw_mode),
    .mfc2_active (mfc2_active),
    .sel_pin     (sel_pin),
    .clr_loss    (clr_loss),
    .miss        (miss),
    .gate_raw    (gate),
    .want        (want),
    .kill        (kill),
    .active_is_b (active_is_b),
    .loss_flag   (loss_flag)
  );

  assign clk_out = |(src_clk & gate);

  assert_gates_exclusive_R8: assert property (@(posedge chk_clk) disable iff (!rst_int_n)
    !(gate[0] && gate[1]));
endmodule

// File: tb/test_refclk_selector.sv
`timescale 1ns/1ps
module test_refclk_selector;
  logic rst_n = 1'b0;
  logic chk_clk = 1'b0, clk_a = 1'b0, clk_b = 1'b0;
  logic run_a = 1'b1, run_b = 1'b1;
  logic prim_is_b = 1'b0, mfc2_active = 1'b0, sel_pin = 1'b0, clr_loss = 1'b0;
  logic [1:0] sw_mode = 2'b00;
  logic [7:0] miss_limit = 8'd16;
  logic clk_out, active_is_b, loss_flag;

  int n_checks = 0, n_fail = 0, out_edges = 0;
  bit finished = 0;
  realtime last_t = 0.0, min_w = 1000.0;
  bit arm = 0;

  always #2 chk_clk = ~chk_clk;
  always begin #5; if (run_a) clk_a = ~clk_a; end
  always begin #7; if (run_b) clk_b = ~clk_b; end

  refclk_selector #(.CNT_W(8)) i_refclk_selector (
    .rst_n(rst_n), .chk_clk(chk_clk), .clk_a(clk_a), .clk_b(clk_b),
    .prim_is_b(prim_is_b), .sw_mode(sw_mode), .mfc2_active(mfc2_active),
    .sel_pin(sel_pin), .clr_loss(clr_loss), .miss_limit(miss_limit),
    .clk_out(clk_out), .active_is_b(active_is_b), .loss_flag(loss_flag));

  always @(posedge clk_out) out_edges++;
  always @(clk_out) begin
    if (arm && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
    last_t = $realtime;
    if (rst_n) arm = 1;
  end

  task automatic check(string req, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // counts output rising edges over 280 ns; A gives 28, B gives 20
  task automatic check_freq(string req, bit exp_b);
    int exp_n, got;
    exp_n = exp_b ? 20 : 28;
    out_edges = 0;
    #280;
    got = out_edges;
    n_checks++;
    if (got < exp_n - 1 || got > exp_n + 1) begin
      n_fail++;
      $display("FAIL %s: got %0d edges expected %0d", req, got, exp_n);
    end
  endtask

  task automatic drive(bit prim, bit pin, logic [1:0] mode, bit mfc2);
    @(negedge chk_clk);
    prim_is_b = prim; sel_pin = pin; sw_mode = mode; mfc2_active = mfc2;
    #100;
  endtask

  task automatic pulse_clr();
    @(negedge chk_clk); clr_loss = 1'b1;
    @(negedge chk_clk); clr_loss = 1'b0;
    #20;
  endtask

  task automatic t_reset();
    #30;
    check("R10 clk_out in reset", int'(clk_out), 0);
    check("R10 status in reset", int'(active_is_b), 0);
    check("R10 loss in reset", int'(loss_flag), 0);
    @(negedge chk_clk); rst_n = 1'b1;
    #150;
  endtask

  task automatic t_manual_a();
    drive(0, 0, 2'b00, 0);
    check("R1 status A", int'(active_is_b), 0);
    check_freq("R1 output follows A", 0);
    check("R7 no loss while running", int'(loss_flag), 0);
  endtask

  task automatic t_manual_sec();
    drive(0, 1, 2'b00, 0);
    check("R3 R9 status secondary B", int'(active_is_b), 1);
    check_freq("R3 output follows B", 1);
    drive(1, 1, 2'b00, 0);
    check("R3 secondary is A when B primary", int'(active_is_b), 0);
    check_freq("R3 output follows A", 0);
  endtask

  task automatic t_prim_b();
    drive(1, 0, 2'b00, 0);
    check("R2 primary B status", int'(active_is_b), 1);
    check_freq("R2 output follows B", 1);
    drive(0, 0, 2'b00, 0);
    check("R2 designation flip swaps to A", int'(active_is_b), 0);
  endtask

  task automatic t_mode01();
    drive(0, 1, 2'b01, 0);
    check("R11 mode 01 manual secondary", int'(active_is_b), 1);
    check_freq("R11 output follows B", 1);
    drive(0, 0, 2'b01, 0);
    check("R11 mode 01 manual primary", int'(active_is_b), 0);
  endtask

  task automatic t_mfc2();
    drive(0, 1, 2'b00, 1);
    check("R4 pin ignored under mfc2", int'(active_is_b), 0);
    check_freq("R4 output follows primary A", 0);
    drive(1, 1, 2'b00, 1);
    check("R4 follows designation B", int'(active_is_b), 1);
    drive(0, 0, 2'b00, 0);
  endtask

  task automatic t_auto();
    drive(0, 1, 2'b10, 0);
    check("R5 pin ignored in auto", int'(active_is_b), 0);
    check_freq("R5 output follows primary A", 0);
    run_a = 1'b0;
    #300;
    check("R6 fallback to secondary B", int'(active_is_b), 1);
    check_freq("R6 output follows B after loss", 1);
    check("R7 loss flag set", int'(loss_flag), 1);
    pulse_clr();
    check("R7 clear ignored while missing", int'(loss_flag), 1);
    run_a = 1'b1;
    #300;
    check("R6 return to primary A", int'(active_is_b), 0);
    check_freq("R6 output follows A again", 0);
    check("R7 loss still sticky", int'(loss_flag), 1);
    pulse_clr();
    check("R7 loss cleared by write", int'(loss_flag), 0);
  endtask

  initial begin
    t_reset();
    t_manual_a();
    t_manual_sec();
    t_prim_b();
    t_mode01();
    t_mfc2();
    t_auto();
    // shortest half period is 5 ns (input A)
    check("R8 narrowest pulse x10ps", int'(min_w >= 4.9), 1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule